// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with Selectable Periodic Rate

This block turns the 32.768 kHz timekeeping clock into the two timing events a real-time clock needs. One is a one-second update strobe for the seconds counter. The other is a periodic interrupt flag whose rate is picked from a set of binary divider taps. The block is clocked directly by the 32.768 kHz clock, so one clock cycle is one tick of the oscillator. A fifteen-stage binary divider chain is held in a single 15-bit count. The 1 Hz strobe is taken from the rising edge of the last stage. The periodic flag is taken from the rising edge of a selected stage.

Software controls the block through one control byte. Bits 6:4 hold a three-bit divider-control code that runs, clears or freezes the chain. Bits 3:0 hold the rate select. Bit 7 is ignored. The periodic flag is sticky and is cleared by a read-and-clear strobe from the register front end. When the chain is released from its cleared state, both events arrive half of their own period later. So the first seconds update comes 500 ms after release.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, `update_pulse` and `periodic_flag` are 0. The control byte resets to 0x60 (divider held at zero, rate select 0).
- R2: A write with `ctl_we` high loads `ctl_wdata` at the clock edge. The divider-control codes 3'b010, 3'b011 and 3'b100 in bits 6:4 advance the chain by one per cycle, and the chain wraps every 32768 cycles.
- R3: Codes 3'b110 and 3'b111 clear all fifteen stages and hold them at zero. No update strobe and no flag set occur while this mode is selected.
- R4: Codes 3'b000 and 3'b001 freeze the chain at its current value and raise no events. A later run code resumes counting from the frozen value.
- R5: `update_pulse` is high for exactly one cycle on each rising edge of the final stage. That is 16384 cycles after the chain is released from zero, and every 32768 cycles after that.
- R6: A rate select n (bits 3:0) from 3 to 15 gives a flag period of 2^(n-1) cycles, which is 65536>>n Hz. Select 1 gives a period of 128 cycles (256 Hz). Select 2 gives a period of 256 cycles (128 Hz).
- R7: The flag is set on the rising edge of the selected stage. The first set therefore comes half a flag period after the chain is released from zero.
- R8: `periodic_flag` stays high until `flag_clr` is seen. If a set and a clear fall in the same cycle, the flag stays high.
- R9: Writing a new rate select does not disturb the chain. The new rate takes effect at the next rising edge of the newly selected stage.
- R10: Rate select 0 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control-byte write strobe |
| ctl_wdata | input | 8 | Control byte: bits 6:4 divider control, bits 3:0 rate select |
| flag_clr | input | 1 | Read-and-clear strobe for the periodic flag |
| update_pulse | output | 1 | One-cycle seconds-update strobe |
| periodic_flag | output | 1 | Sticky periodic interrupt flag |

## Verification
The assertions assume that the write strobe and the clear strobe are synchronous to the timekeeping clock, are stable around each edge, and are each one cycle wide. The stimulus drives every input half a cycle away from the active edge. It issues writes as single-cycle strobes, so each mode and rate change occupies exactly one edge. The clear strobe is pulsed on a fixed stride that is chosen to coincide with flag sets. This means the set-wins case is reached during the fast-rate phases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        DIV_FREEZE = 2'd0,
        DIV_RUN    = 2'd1,
        DIV_CLEAR  = 2'd2
    } div_mode_e;

    // Map the three-bit divider-control code onto a chain mode.
    function automatic div_mode_e decode_div(input logic [2:0] code);
        div_mode_e m;
        if (code[2:1] == 2'b11) begin
            m = DIV_CLEAR;
        end else if (code[2:1] == 2'b01 || code == 3'b100) begin
            m = DIV_RUN;
        end else begin
            m = DIV_FREEZE;
        end
        return m;
    endfunction

endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
    import rtc_pkg::*;
#(
    parameter int CTL_W  = 8,
    parameter int SEL_W  = 4,
    parameter logic [CTL_W-1:0] RST_VAL = 8'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output div_mode_e        mode,
    output logic [SEL_W-1:0] rate_sel
);
    localparam int DV_LO = SEL_W;

    typedef struct packed {
        logic [2:0]       dv;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.dv  = wdata[DV_LO +: 3];
            st_d.sel = wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dv  <= RST_VAL[DV_LO +: 3];
            st_q.sel <= RST_VAL[SEL_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = decode_div(st_q.dv);
    assign rate_sel = st_q.sel;

    // R2: a write lands in the held fields on the next edge
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rate_sel == $past(wdata[SEL_W-1:0]));

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
    import rtc_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  div_mode_e         mode,
    output logic [STAGES-1:0] rise,
    output logic              upd
);
    localparam logic [STAGES-1:0] ONE    = STAGES'(1);
    localparam logic [STAGES-1:0] TOPBIT = ONE << (STAGES - 1);

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic              upd;
    } chain_t;

    chain_t st_d, st_q;
    logic [STAGES-1:0] inc;

    assign inc = st_q.cnt + ONE;

    // Rising edge of each divide-by-two stage on the coming edge
    for (genvar k = 0; k < STAGES; k++) begin : g_rise
        assign rise[k] = (mode == DIV_RUN) && !st_q.cnt[k] && inc[k];
    end

    always_comb begin
        st_d = st_q;
        st_d.upd = rise[STAGES-1];
        unique case (mode)
            DIV_RUN:   st_d.cnt = inc;
            DIV_CLEAR: st_d.cnt = '0;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd = st_q.upd;

    // R3: clear mode leaves every stage at zero and no strobe
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode == DIV_CLEAR |=> st_q.cnt == '0 && !upd);
    // R4: freeze mode keeps the chain value
    a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode == DIV_FREEZE |=> $stable(st_q.cnt));
    // R5: strobe only at the top-stage transition, single cycle
    a_r5_upd_position: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> st_q.cnt == TOPBIT);
    a_r5_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

endmodule

// File: rtl/rtc_tap_flag.sv
module rtc_tap_flag #(
    parameter int STAGES = 15,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] rise,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic              clr,
    output logic              flag
);
    // Selects 1 and 2 reuse the 256 Hz and 128 Hz stages
    localparam int SLOW_TAP1 = STAGES - 9;
    localparam int SLOW_TAP2 = STAGES - 8;

    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;
    int    tap;
    logic  set;

    always_comb begin
        if (rate_sel == SEL_W'(1)) begin
            tap = SLOW_TAP1;
        end else if (rate_sel == SEL_W'(2)) begin
            tap = SLOW_TAP2;
        end else begin
            tap = int'(rate_sel) - 2;
        end
    end

    always_comb begin
        set = 1'b0;
        if (rate_sel != '0) begin
            for (int k = 0; k < STAGES; k++) begin
                if (tap == k) begin
                    set = rise[k];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R8: set beats a simultaneous clear; a lone clear drops the flag
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set && clr) |=> flag);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && clr) |=> !flag);
    // R8: sticky without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R10: rate zero never raises the flag
    a_r10_rate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0 && !flag) |=> !flag);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int STAGES = 15,
    parameter int SEL_W  = 4,
    parameter int CTL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             flag_clr,
    output logic             update_pulse,
    output logic             periodic_flag
);
    div_mode_e         mode;
    logic [SEL_W-1:0]  rate_sel;
    logic [STAGES-1:0] rise;

    rtc_ctl_reg #(.CTL_W(CTL_W), .SEL_W(SEL_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .mode     (mode),
        .rate_sel (rate_sel)
    );

    rtc_div_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .rise  (rise),
        .upd   (update_pulse)
    );

    rtc_tap_flag #(.STAGES(STAGES), .SEL_W(SEL_W)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .rate_sel (rate_sel),
        .clr      (flag_clr),
        .flag     (periodic_flag)
    );

    // R1: outputs quiet in the first cycle after reset release
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !update_pulse && !periodic_flag);

endmodule

// File: tb/tb_rtc_prescaler.sv
module tb_rtc_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       flag_clr = 1'b0;
    logic       update_pulse, periodic_flag;

    always #4 clk = ~clk;

    rtc_prescaler dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .flag_clr(flag_clr), .update_pulse(update_pulse),
        .periodic_flag(periodic_flag)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference
    int m_cnt = 0;
    int m_dv = 6;
    int m_sel = 0;
    bit m_upd = 0;
    bit m_flag = 0;

    function automatic int period_of(int sel);
        int hz;
        if (sel == 1) hz = 256;
        else if (sel == 2) hz = 128;
        else hz = 65536 >> sel;
        return 32768 / hz;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dv = 6; m_sel = 0; m_upd = 0; m_flag = 0;
        end else begin
            bit running;
            bit set;
            int p;
            running = (m_dv == 2 || m_dv == 3 || m_dv == 4);
            m_upd = running && (m_cnt == 16383);
            set = 0;
            if (running && m_sel != 0) begin
                p = period_of(m_sel);
                set = (((m_cnt + 1) % p) == p / 2);
            end
            m_flag = set | (m_flag & ~flag_clr);
            if (m_dv >= 6) m_cnt = 0;
            else if (running) m_cnt = (m_cnt + 1) % 32768;
            if (ctl_we) begin
                m_dv = (ctl_wdata >> 4) & 7;
                m_sel = ctl_wdata & 15;
            end
        end
    end

    task automatic check(input string what, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b",
                     tag, what, cycles, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("update_pulse", update_pulse, m_upd);
            check("periodic_flag", periodic_flag, m_flag);
        end
    end

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic run(input int n, input int clr_stride);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            flag_clr = (clr_stride != 0) && (i % clr_stride == 0);
        end
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // first strobe distance measured directly at the port (R5)
    task automatic time_first_update(input int limit, output int seen);
        seen = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (update_pulse && seen < 0) seen = i;
        end
    endtask

    initial begin
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check("reset update", update_pulse, 1'b0);
        check("reset flag", periodic_flag, 1'b0);
        run(40, 0);                          // R1/R3: held at zero from reset, quiet

        tag = "R10";
        write_ctl(8'h20);                    // run, rate 0
        run(300, 0);

        tag = "R3";
        write_ctl(8'h73);                    // clear, rate 3
        run(50, 0);

        tag = "R7";
        write_ctl(8'h23);                    // R2 run 010, rate 3: period 4
        run(2000, 3);                        // clears collide with sets (R8)
        tag = "R6";
        write_ctl(8'hA1);                    // bit7 ignored, run 010, rate 1
        run(1000, 50);
        tag = "R9";
        write_ctl(8'h22);                    // rate 2 without chain reset
        run(1000, 97);

        tag = "R5";
        write_ctl(8'h6F);                    // clear
        run(20, 0);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 8'h4F;    // run 100, rate 15
        @(negedge clk);
        ctl_we = 1'b0;
        time_first_update(20000, first);
        total++;
        // write edge then 16384 counts; strobe registered one edge later
        if (first != 16384) begin
            bad++;
            $display("FAIL R5 first update distance: actual=%0d expected=%0d", first, 16384);
        end
        run(40000, 5000);

        tag = "R4";
        write_ctl(8'h07);                    // freeze 000, rate 7
        run(500, 0);
        write_ctl(8'h17);                    // freeze 001
        run(200, 0);
        tag = "R2";
        write_ctl(8'h37);                    // run 011 resumes
        run(20000, 700);

        tag = "R8";
        write_ctl(8'h24);
        run(500, 0);                         // flag sticky, no clears
        run(200, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog %s: actual=timeout expected=finish", tag);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule